// File: doc/BRIEF.md
# Host Memory Access Slave Port

This block lets an external processor read and write on-chip program memory and data memory over a 16-bit host bus. The host first latches a control word: bit 15 picks the target, either the address pointer with its memory-type bit or a separate overlay register. After that, every strobed read or write moves one word through an auto-incrementing pointer. Program-memory words are 24 bits wide, so each one moves as two host transfers. Data-memory words move as one transfer.

Toward the memories the port raises a single valid/ready request carrying direction, memory type, overlay, address and write data. Back-pressure rule: once `m_valid` rises, every request field stays unchanged until the cycle in which `m_ready` is high, and the request is taken on that edge. Read data must be presented on `m_rdata` in the same cycle as `m_ready`. The core can reach the control word at data address 0x3FE0 and the overlay at 0x3FE7 through a small register port. The host has no path to read back the pointer.

Top module: `hdp_port`

## Requirements
- R1: With `h_sel` and `h_ale` high and the port idle, a clock edge with `h_din[15]`=0 loads the pointer from `h_din[13:0]` and the memory-type bit from `h_din[14]` (0 = program memory, 1 = data memory). It also restarts the program-word half sequence at the upper half.
- R2: The same latch with `h_din[15]`=1 loads the overlay from `h_din[OVL_W-1:0]` and leaves the pointer and type unchanged. The overlay appears on `m_ovl` with each request.
- R3: A transfer starts when the port is idle and `h_sel` is high with `h_rd` or `h_wr` at a clock edge k. `h_ack` is low after edge k and rises after edge k+2+s, where s is the number of cycles `m_valid` waits with `m_ready` low. The first cycle is a synchronization cycle, the second is the memory (or staging) cycle.
- R4: In data-memory mode, a write sends `h_din` to `m_wdata[15:0]` with `m_we`=1 and `m_is_dm`=1 at the pointer address. A read returns `m_rdata[15:0]` on `h_dout`. The host only ever sees memory data, never the pointer.
- R5: The pointer increments by one after each data-memory access, and after the second half of each program-memory word.
- R6: In program-memory mode, the first write transfer stores the upper 16 bits internally and issues no memory request. The second write transfer writes `{upper16, h_din[7:0]}` to program memory.
- R7: In program-memory mode, the first read transfer fetches the 24-bit word and returns bits 23:8. The second read transfer returns bits 7:0 zero-extended and issues no memory request.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_we`, `m_is_dm`, `m_ovl`, `m_addr` and `m_wdata` hold their values.
- R9: A core write to 0x3FE0 acts like a host latch of the written value (bit 15 again selects pointer or overlay). A core write to 0x3FE7 loads the overlay. Core reads return `{0, type, pointer}` at 0x3FE0 and the zero-extended overlay at 0x3FE7. A host latch in the same cycle wins.
- R10: A strobe held high after the acknowledge produces no further access. A new transfer needs the strobe to drop first.
- R11: After reset `h_ack`=1, `m_valid`=0, and the pointer, type, overlay and half state are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host port select |
| h_ale | input | 1 | Host address/overlay latch enable |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_din | input | 16 | Host bus, host to port |
| h_dout | output | 16 | Host bus, port to host (read data) |
| h_ack | output | 1 | High when the port is not busy with a transfer |
| core_en | input | 1 | Core register access enable |
| core_we | input | 1 | Core write (1) or read (0) |
| core_addr | input | 14 | Core data address |
| core_wdata | input | 16 | Core write data |
| core_rdata | output | 16 | Core read data |
| m_valid | output | 1 | Memory request valid |
| m_ready | input | 1 | Memory grants the request this cycle |
| m_we | output | 1 | Request is a write |
| m_is_dm | output | 1 | 1 = data memory, 0 = program memory |
| m_ovl | output | OVL_W | Overlay value for the request |
| m_addr | output | 14 | Word address |
| m_wdata | output | 24 | Write data (data memory uses bits 15:0) |
| m_rdata | input | 24 | Read data, valid with m_ready |

## Verification
The assertions assume that the host holds `h_din` and its strobe level steady from the sampling edge until `h_ack` returns, and that the core does not write the control or overlay register while a memory request is pending. The request-stability check would otherwise see the pointer move under a stalled request. The bench drives all host and core inputs on falling edges and starts each core access only while `h_ack` is high. Its memory model lowers `m_ready` for a preset number of cycles per request, so stalled and unstalled grants are both covered without breaking those assumptions.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
  localparam int HDW      = 16;  // host bus width
  localparam int AW       = 14;  // pointer width
  localparam int PMW      = 24;  // program word width
  localparam int LOW_W    = PMW - HDW;
  localparam int TYPE_BIT = 14;  // memory-type bit in control word
  localparam int SEL_BIT  = 15;  // pointer/overlay select bit

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SYNC  = 3'd1,
    ST_MEM   = 3'd2,
    ST_LOCAL = 3'd3,
    ST_HOLD  = 3'd4
  } seq_t;
endpackage

// File: rtl/hdp_regs.sv
module hdp_regs
  import hdp_pkg::*;
#(
  parameter int          OVL_W     = 4,
  parameter logic [13:0] CTRL_ADDR = 14'h3FE0,
  parameter logic [13:0] OVL_ADDR  = 14'h3FE7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lat_en,
  input  logic [HDW-1:0]   lat_din,
  input  logic             core_en,
  input  logic             core_we,
  input  logic [13:0]      core_addr,
  input  logic [HDW-1:0]   core_wdata,
  output logic [HDW-1:0]   core_rdata,
  input  logic             inc,
  output logic [AW-1:0]    ptr,
  output logic             is_dm,
  output logic [OVL_W-1:0] ovl,
  output logic             ptr_load
);
  logic            core_ctrl_wr, core_ovl_wr;
  logic            wr_any;
  logic [HDW-1:0]  wr_word;
  logic            ovl_from_word;

  assign core_ctrl_wr = core_en && core_we && (core_addr == CTRL_ADDR);
  assign core_ovl_wr  = core_en && core_we && (core_addr == OVL_ADDR);

  // host latch has priority over core control writes
  assign wr_any        = lat_en || core_ctrl_wr;
  assign wr_word       = lat_en ? lat_din : core_wdata;
  assign ovl_from_word = wr_word[SEL_BIT];
  assign ptr_load      = wr_any && !ovl_from_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      is_dm <= 1'b0;
      ovl   <= '0;
    end else begin
      if (ptr_load) begin
        ptr   <= wr_word[AW-1:0];
        is_dm <= wr_word[TYPE_BIT];
      end else if (inc) begin
        ptr <= ptr + AW'(1);
      end
      if (wr_any && ovl_from_word)
        ovl <= wr_word[OVL_W-1:0];
      else if (core_ovl_wr && !lat_en)
        ovl <= core_wdata[OVL_W-1:0];
    end
  end

  always_comb begin
    core_rdata = '0;
    if (core_en && !core_we) begin
      if (core_addr == CTRL_ADDR)
        core_rdata = {1'b0, is_dm, ptr};
      else if (core_addr == OVL_ADDR)
        core_rdata = {{(HDW-OVL_W){1'b0}}, ovl};
    end
  end

  assert_latch_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_en && !lat_din[SEL_BIT]) |=>
      (ptr == $past(lat_din[AW-1:0])) && (is_dm == $past(lat_din[TYPE_BIT])));

  assert_ovl_keeps_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_en && lat_din[SEL_BIT] && !inc) |=>
      (ptr == $past(ptr)) && (ovl == $past(lat_din[OVL_W-1:0])));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ptr_load) |=> (ptr == $past(ptr) + AW'(1)));
endmodule

// File: rtl/hdp_seq.sv
module hdp_seq
  import hdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic strobe,
  input  logic need_mem,
  input  logic m_ready,
  output logic idle,
  output logic ack,
  output logic m_valid,
  output logic done
);
  seq_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (start) st_nx = ST_SYNC;
      ST_SYNC:  st_nx = need_mem ? ST_MEM : ST_LOCAL;
      ST_MEM:   if (m_ready) st_nx = ST_HOLD;
      ST_LOCAL: st_nx = ST_HOLD;
      ST_HOLD:  if (!strobe) st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign idle    = (st == ST_IDLE);
  assign ack     = (st == ST_IDLE) || (st == ST_HOLD);
  assign m_valid = (st == ST_MEM);
  assign done    = ((st == ST_MEM) && m_ready) || (st == ST_LOCAL);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid);

  assert_ack_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |=> ack);

  assert_sync_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!ack && !m_valid));

  assert_one_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !idle && strobe) |=> (ack && !m_valid));
endmodule

// File: rtl/hdp_pack.sv
module hdp_pack
  import hdp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_wr,
  input  logic            cur_dm,
  input  logic [HDW-1:0]  h_din,
  input  logic            clr_half,
  input  logic            done,
  input  logic [PMW-1:0]  m_rdata,
  output logic            need_mem,
  output logic            op_wr,
  output logic            op_dm,
  output logic [PMW-1:0]  m_wdata,
  output logic [HDW-1:0]  h_dout,
  output logic            inc
);
  logic             half;      // 0 = upper part next, 1 = lower part next
  logic [HDW-1:0]   wbuf;
  logic [HDW-1:0]   hi_stage;
  logic [LOW_W-1:0] lo_stage;

  always_comb begin
    if (op_dm)      need_mem = 1'b1;
    else if (op_wr) need_mem = half;
    else            need_mem = !half;
  end

  assign m_wdata = op_dm ? {{LOW_W{1'b0}}, wbuf} : {hi_stage, wbuf[LOW_W-1:0]};
  assign inc     = done && (op_dm || half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half     <= 1'b0;
      op_wr    <= 1'b0;
      op_dm    <= 1'b0;
      wbuf     <= '0;
      hi_stage <= '0;
      lo_stage <= '0;
      h_dout   <= '0;
    end else begin
      if (start) begin
        op_wr <= start_wr;
        op_dm <= cur_dm;
        wbuf  <= h_din;
      end
      if (done) begin
        if (op_dm) begin
          if (!op_wr) h_dout <= m_rdata[HDW-1:0];
        end else if (op_wr) begin
          if (!half) hi_stage <= wbuf;
        end else if (!half) begin
          h_dout   <= m_rdata[PMW-1:LOW_W];
          lo_stage <= m_rdata[LOW_W-1:0];
        end else begin
          h_dout <= {{(HDW-LOW_W){1'b0}}, lo_stage};
        end
      end
      if (clr_half)
        half <= 1'b0;
      else if (done && !op_dm)
        half <= !half;
    end
  end

  assert_pm_half_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_dm && !clr_half) |=> (half != $past(half)));

  assert_pm_local_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !op_dm && !op_wr && half && !clr_half) |=>
      (h_dout == {{(HDW-LOW_W){1'b0}}, $past(lo_stage)}));
endmodule

// File: rtl/hdp_port.sv
module hdp_port
  import hdp_pkg::*;
#(
  parameter int          OVL_W     = 4,
  parameter logic [13:0] CTRL_ADDR = 14'h3FE0,
  parameter logic [13:0] OVL_ADDR  = 14'h3FE7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_sel,
  input  logic             h_ale,
  input  logic             h_rd,
  input  logic             h_wr,
  input  logic [15:0]      h_din,
  output logic [15:0]      h_dout,
  output logic             h_ack,
  input  logic             core_en,
  input  logic             core_we,
  input  logic [13:0]      core_addr,
  input  logic [15:0]      core_wdata,
  output logic [15:0]      core_rdata,
  output logic             m_valid,
  input  logic             m_ready,
  output logic             m_we,
  output logic             m_is_dm,
  output logic [OVL_W-1:0] m_ovl,
  output logic [13:0]      m_addr,
  output logic [23:0]      m_wdata,
  input  logic [23:0]      m_rdata
);
  logic idle, done, need_mem, inc, ptr_load;
  logic strobe, start, lat_en;
  logic cur_dm;

  assign strobe = h_sel && (h_rd || h_wr);
  assign start  = idle && strobe && !h_ale;
  assign lat_en = idle && h_sel && h_ale;

  hdp_regs #(.OVL_W(OVL_W), .CTRL_ADDR(CTRL_ADDR), .OVL_ADDR(OVL_ADDR)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .lat_en(lat_en), .lat_din(h_din),
    .core_en(core_en), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata),
    .inc(inc), .ptr(m_addr), .is_dm(cur_dm), .ovl(m_ovl), .ptr_load(ptr_load)
  );

  hdp_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .strobe(strobe),
    .need_mem(need_mem), .m_ready(m_ready),
    .idle(idle), .ack(h_ack), .m_valid(m_valid), .done(done)
  );

  hdp_pack pack_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(h_wr),
    .cur_dm(cur_dm), .h_din(h_din), .clr_half(ptr_load), .done(done),
    .m_rdata(m_rdata), .need_mem(need_mem), .op_wr(m_we), .op_dm(m_is_dm),
    .m_wdata(m_wdata), .h_dout(h_dout), .inc(inc)
  );

  assert_req_fields_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> ($stable(m_addr) && $stable(m_wdata) && $stable(m_we)
                               && $stable(m_is_dm) && $stable(m_ovl)));

  assert_busy_no_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_ack && !done) |=> $stable(m_addr));
endmodule

// File: tb/hdp_port_tb_top.sv
module hdp_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        h_sel = 0, h_ale = 0, h_rd = 0, h_wr = 0;
  logic [15:0] h_din = '0;
  logic [15:0] h_dout;
  logic        h_ack;
  logic        core_en = 0, core_we = 0;
  logic [13:0] core_addr = '0;
  logic [15:0] core_wdata = '0;
  logic [15:0] core_rdata;
  logic        m_valid, m_ready, m_we, m_is_dm;
  logic [3:0]  m_ovl;
  logic [13:0] m_addr;
  logic [23:0] m_wdata, m_rdata;

  hdp_port dut_i (
    .clk(clk), .rst_n(rst_n), .h_sel(h_sel), .h_ale(h_ale), .h_rd(h_rd), .h_wr(h_wr),
    .h_din(h_din), .h_dout(h_dout), .h_ack(h_ack),
    .core_en(core_en), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_rdata(core_rdata),
    .m_valid(m_valid), .m_ready(m_ready), .m_we(m_we), .m_is_dm(m_is_dm),
    .m_ovl(m_ovl), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata)
  );

  int checks = 0, errors = 0, cycles = 0, grants = 0, wait_cnt = 0;

  // memory seen by the port
  logic [23:0] mem_pm [1024];
  logic [15:0] mem_dm [1024];
  // reference model state
  logic [23:0] ref_pm [1024];
  logic [15:0] ref_dm [1024];
  int mptr = 0, movl = 0, mtype = 0, mhalf = 0;
  logic [15:0] mhi = '0;
  logic [7:0]  mlo = '0;
  logic [23:0] exp_wdata = '0;

  function automatic int idx(input int o, input int a);
    return ((o & 3) << 8) | (a & 255);
  endfunction

  assign m_ready = m_valid && (wait_cnt == 0);
  assign m_rdata = m_is_dm ? {8'h00, mem_dm[idx(m_ovl, m_addr)]} : mem_pm[idx(m_ovl, m_addr)];

  always @(posedge clk) begin
    if (m_valid && wait_cnt > 0) wait_cnt <= wait_cnt - 1;
    if (m_valid && m_ready) begin
      grants <= grants + 1;
      if (m_we) begin
        if (m_is_dm) mem_dm[idx(m_ovl, m_addr)] <= m_wdata[15:0];
        else         mem_pm[idx(m_ovl, m_addr)] <= m_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // reference comparison on every clock while a request is up (R4, R2, R6)
  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
    if (rst_n && m_valid) begin
      chk(m_addr == mptr[13:0], "R4", "m_addr", m_addr, mptr);
      chk(m_is_dm == mtype[0], "R4", "m_is_dm", m_is_dm, mtype);
      chk(m_ovl == movl[3:0], "R2", "m_ovl", m_ovl, movl);
      if (m_we) chk(m_wdata == exp_wdata, "R6", "m_wdata", m_wdata, exp_wdata);
    end
  end

  task automatic host_latch(input logic [15:0] v);
    @(negedge clk); h_sel = 1; h_ale = 1; h_din = v;
    @(negedge clk); h_sel = 0; h_ale = 0;
    if (!v[15]) begin mptr = v[13:0]; mtype = v[14]; mhalf = 0; end
    else movl = v[3:0];
  endtask

  task automatic core_write(input logic [13:0] a, input logic [15:0] d);
    @(negedge clk); core_en = 1; core_we = 1; core_addr = a; core_wdata = d;
    @(negedge clk); core_en = 0; core_we = 0;
    if (a == 14'h3FE0) begin
      if (!d[15]) begin mptr = d[13:0]; mtype = d[14]; mhalf = 0; end
      else movl = d[3:0];
    end else if (a == 14'h3FE7) movl = d[3:0];
  endtask

  task automatic core_check(input logic [13:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); core_en = 1; core_we = 0; core_addr = a;
    #1 chk(core_rdata == exp, req, "core_rdata", core_rdata, exp);
    @(negedge clk); core_en = 0;
  endtask

  // one host transfer; checks ack timing and read data against the model
  task automatic host_xfer(input bit wr, input logic [15:0] d, input int stall, input int hold);
    bit mem;
    int cnt, k, g0;
    logic [15:0] exp;
    mem = (mtype != 0) ? 1'b1 : (wr ? (mhalf != 0) : (mhalf == 0));
    k = idx(movl, mptr);
    if (mtype != 0) exp_wdata = {8'h00, d};
    else            exp_wdata = {mhi, d[7:0]};
    g0 = grants;
    @(negedge clk); h_sel = 1; h_wr = wr; h_rd = !wr; h_din = d; wait_cnt = stall;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!h_ack && cnt < 40);
    chk(cnt == (mem ? 3 + stall : 3), "R3", "ack edges", cnt, mem ? 3 + stall : 3);
    // model update and expected read data
    exp = 'x;
    if (mtype != 0) begin
      if (wr) ref_dm[k] = d; else exp = ref_dm[k];
      mptr++;
    end else if (wr) begin
      if (mhalf == 0) mhi = d; else begin ref_pm[k] = {mhi, d[7:0]}; mptr++; end
      mhalf = 1 - mhalf;
    end else begin
      if (mhalf == 0) begin exp = ref_pm[k][23:8]; mlo = ref_pm[k][7:0]; end
      else begin exp = {8'h00, mlo}; mptr++; end
      mhalf = 1 - mhalf;
    end
    if (!wr) chk(h_dout == exp, (mtype != 0) ? "R4" : "R7", "h_dout", h_dout, exp);
    chk((grants - g0) == (mem ? 1 : 0), (mtype != 0) ? "R4" : "R6", "requests", grants - g0, mem ? 1 : 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(h_ack == 1'b1, "R10", "ack while held", h_ack, 1);
    end
    g0 = grants;
    h_sel = 0; h_rd = 0; h_wr = 0;
    @(negedge clk);
    if (hold > 0) chk(grants == g0, "R10", "extra access", grants - g0, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem_pm[i] = 24'(i * 24'h01_3579 + 24'h00_0A5C);
      mem_dm[i] = 16'(i * 16'h2468 + 16'h1111);
      ref_pm[i] = mem_pm[i];
      ref_dm[i] = mem_dm[i];
    end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(h_ack == 1'b1, "R11", "ack at reset", h_ack, 1);
    chk(m_valid == 1'b0, "R11", "valid at reset", m_valid, 0);
    rst_n = 1;
    core_check(14'h3FE0, 16'h0000, "R11");
    core_check(14'h3FE7, 16'h0000, "R11");

    // R1 / R9: latch data-memory pointer, read it through the core port
    host_latch(16'h4010);
    core_check(14'h3FE0, 16'h4010, "R1");
    // R4, R5, R8, R3: data-memory writes with varied stalls
    host_xfer(1, 16'hBEEF, 0, 0);
    host_xfer(1, 16'h1234, 2, 0);
    host_xfer(1, 16'hA5A5, 1, 0);
    core_check(14'h3FE0, 16'h4013, "R5");
    host_latch(16'h4010);
    host_xfer(0, 16'h0, 0, 0);
    host_xfer(0, 16'h0, 3, 0);
    host_xfer(0, 16'h0, 0, 0);

    // R2: overlay latch leaves pointer alone
    host_latch(16'h8002);
    core_check(14'h3FE7, 16'h0002, "R2");
    core_check(14'h3FE0, 16'h4013, "R2");
    host_xfer(1, 16'h7777, 1, 0);
    host_xfer(0, 16'h0, 0, 0);

    // R6 / R7: program-memory words in two halves
    host_latch(16'h0020);
    host_xfer(1, 16'hCAFE, 5, 0);
    host_xfer(1, 16'h0042, 0, 0);
    host_xfer(1, 16'h1357, 4, 0);
    host_xfer(1, 16'h00F0, 2, 0);
    core_check(14'h3FE0, 16'h0022, "R5");
    host_latch(16'h0020);
    host_xfer(0, 16'h0, 1, 0);
    host_xfer(0, 16'h0, 6, 0);
    host_xfer(0, 16'h0, 0, 0);
    host_xfer(0, 16'h0, 0, 0);
    host_xfer(0, 16'h0, 2, 0);   // untouched word, upper half
    host_latch(16'h0030);        // R1: latch restarts at upper half
    host_xfer(0, 16'h0, 0, 0);

    // R9: core writes to control and overlay
    core_write(14'h3FE0, 16'h4005);
    core_write(14'h3FE7, 16'h0001);
    core_check(14'h3FE7, 16'h0001, "R9");
    core_check(14'h3FE0, 16'h4005, "R9");
    host_xfer(0, 16'h0, 0, 0);
    // R9: host latch wins over same-cycle core write
    @(negedge clk); h_sel = 1; h_ale = 1; h_din = 16'h4040;
    core_en = 1; core_we = 1; core_addr = 14'h3FE0; core_wdata = 16'h4077;
    @(negedge clk); h_sel = 0; h_ale = 0; core_en = 0; core_we = 0;
    mptr = 14'h40; mtype = 1; mhalf = 0;
    core_check(14'h3FE0, 16'h4040, "R9");

    // R10: strobe held long after ack
    host_xfer(1, 16'h5151, 0, 5);
    host_xfer(0, 16'h0, 0, 4);
    core_check(14'h3FE0, 16'h4042, "R10");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule